// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a 48-bit virtual address into a physical address by walking a four-level radix page table in memory. A client presents the virtual address, a write flag and a root-table base. The walker first checks that the address is in canonical form. It then reads one 64-bit entry per level over a single valid/ready memory port. At each level it checks the entry for presence and reserved bits, and it collects the user, write and execute rights along the path.

A walk ends at a 4 KiB entry, or earlier at a 1 GiB or 2 MiB large-page entry. The walker sets the accessed bit in each table entry and writes the entry back. At the leaf it also sets the dirty bit when the access is a write. The result is a one-cycle completion pulse that carries the physical address, the page size and the accumulated rights, or one of three fault codes. A separate unit makes the final allow or deny decision from the rights. Only one walk is in progress at a time. While the busy output is high, new requests are ignored.

Top module: `pt_walker`

## Requirements
- R1: When bits 63:47 of the virtual address are not all equal, the walk ends with fault code 1 (general protection), and no memory access is made. On any fault, page size reads 0 and the rights read 0.
- R2: The first entry is read at (root with bits 11:0 cleared) + 8*VA[47:39]. Each following entry is read at (previous entry bits 51:12, shifted left 12) + 8*index, where the index is VA[38:30], then VA[29:21], then VA[20:12].
- R3: An entry whose bit 0 (present) is clear ends the walk with fault code 2. Nothing is written back.
- R4: Fault code 3 (reserved) results from any of these: an entry with any of bits 51:PHYS_BITS set; an entry with bit 63 set while nxe is low; a top-level entry with bit 7 set.
- R5: A non-leaf entry whose bit 5 (accessed) is clear is written back to its own address with bit 5 set, before the next level is read.
- R6: Bit 7 set in a level-3 entry ends the walk with page size code 2 (1 GiB). Bit 7 set in a level-2 entry ends it with code 1 (2 MiB). Otherwise the walk ends at level 1 with code 0 (4 KiB).
- R7: A large-page leaf with any frame bit set below its page size (bits 29:13 for 1 GiB, bits 20:13 for 2 MiB) gives fault code 3. Bit 12 is exempt.
- R8: The user right is the AND of bit 2 over all entries read, and the write right is the AND of bit 1. The execute right is 1 only when no entry read has bit 63 set.
- R9: The leaf gets bit 5 set, and also bit 6 (dirty) when req_write is high. The leaf is written back once, and only when this changes it.
- R10: The physical address is the leaf frame with the bits below the page size taken from the virtual address.
- R11: busy is low in idle and goes high the cycle after a request is accepted. Requests while busy are ignored. done is high for exactly one cycle per walk.
- R12: A memory request keeps its valid, address and write flag until ready is seen. Each entry is read exactly once per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 64 | Virtual address |
| req_write | input | 1 | Access is a write |
| root | input | 64 | Root table base (bits 11:0 ignored) |
| nxe | input | 1 | No-execute enable |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write-back |
| mem_req_addr | output | 64 | Entry byte address |
| mem_req_wdata | output | 64 | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 64 | Entry read data |
| done | output | 1 | Result pulse |
| fault | output | 2 | 0 ok, 1 general protection, 2 not present, 3 reserved |
| pa | output | PHYS_BITS | Physical address |
| psize | output | 2 | 0 4 KiB, 1 2 MiB, 2 1 GiB |
| rt_user | output | 1 | Accumulated user right |
| rt_write | output | 1 | Accumulated write right |
| rt_exec | output | 1 | Accumulated execute right |

## Verification
The same 4 KiB path is walked three times: a read with clear accessed bits, then a write, then a read again. This separates the first write-back of accessed bits, the dirty-only update, and the case where nothing is written. Large pages are tried aligned, with only the exempt bit 12 set, and with a misaligned frame bit, which separates the size masks from the alignment check. Faults are triggered at different depths (non-canonical addresses in both halves, absent entries, bits above the physical width, NX with no-execute disabled, page-size at the top level), and the read and write counts show where each walk stopped. Rights are checked on paths where only one middle entry drops write or sets NX, and a stray request during a walk checks that it is ignored.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PHYS_BITS = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [63:0]          req_vaddr,
  input  logic                 req_write,
  input  logic [63:0]          root,
  input  logic                 nxe,
  output logic                 busy,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_req_we,
  output logic [63:0]          mem_req_addr,
  output logic [63:0]          mem_req_wdata,
  input  logic                 mem_rsp_valid,
  input  logic [63:0]          mem_rsp_rdata,
  output logic                 done,
  output logic [1:0]           fault,
  output logic [PHYS_BITS-1:0] pa,
  output logic [1:0]           psize,
  output logic                 rt_user,
  output logic                 rt_write,
  output logic                 rt_exec
);
  localparam logic [1:0] F_OK = 2'd0, F_GP = 2'd1, F_NP = 2'd2, F_RSV = 2'd3;
  localparam logic [PHYS_BITS-1:0] M4K = {{(PHYS_BITS-12){1'b0}}, {12{1'b1}}};
  localparam logic [PHYS_BITS-1:0] M2M = {{(PHYS_BITS-21){1'b0}}, {21{1'b1}}};
  localparam logic [PHYS_BITS-1:0] M1G = {{(PHYS_BITS-30){1'b0}}, {30{1'b1}}};
  localparam logic [63:0] A_SET = 64'h20, D_SET = 64'h40;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WB, S_DONE} st_t;

  st_t         st;
  logic [1:0]  lvl;
  logic [63:0] tbl, ent;
  logic [47:0] va;
  logic        wr, leaf_q;

  logic [8:0]  idx;
  logic [63:0] e, newe;
  logic        canon, ps, big, leaf, hi_rsv, align_rsv, rsv;
  logic [PHYS_BITS-1:0] mask;

  assign idx  = va[12 + 9*int'(lvl) +: 9];
  assign e    = mem_rsp_rdata;
  assign ps   = e[7];
  assign big  = ps && (lvl == 2'd2 || lvl == 2'd1);
  assign leaf = (lvl == 2'd0) || big;
  assign hi_rsv    = |e[51:PHYS_BITS];
  assign align_rsv = (lvl == 2'd2 && ps && |e[29:13]) || (lvl == 2'd1 && ps && |e[20:13]);
  assign rsv  = hi_rsv || (!nxe && e[63]) || (lvl == 2'd3 && ps) || align_rsv;
  assign newe = e | A_SET | ((leaf && wr) ? D_SET : 64'h0);
  assign mask = (lvl == 2'd2) ? M1G : (lvl == 2'd1) ? M2M : M4K;
  assign canon = (&req_vaddr[63:47]) || !(|req_vaddr[63:47]);

  assign busy          = st != S_IDLE;
  assign done          = st == S_DONE;
  assign mem_req_valid = st == S_RD || st == S_WB;
  assign mem_req_we    = st == S_WB;
  assign mem_req_addr  = tbl + {52'h0, idx, 3'b000};
  assign mem_req_wdata = ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lvl <= 2'd3;
      tbl <= '0;
      ent <= '0;
      va <= '0;
      wr <= 1'b0;
      leaf_q <= 1'b0;
      fault <= F_OK;
      pa <= '0;
      psize <= 2'd0;
      rt_user <= 1'b0;
      rt_write <= 1'b0;
      rt_exec <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va <= req_vaddr[47:0];
          wr <= req_write;
          lvl <= 2'd3;
          tbl <= root & ~64'hFFF;
          pa <= '0;
          psize <= 2'd0;
          leaf_q <= 1'b0;
          if (canon) begin
            fault <= F_OK;
            {rt_user, rt_write, rt_exec} <= 3'b111;
            st <= S_RD;
          end else begin
            fault <= F_GP;
            {rt_user, rt_write, rt_exec} <= 3'b000;
            st <= S_DONE;
          end
        end
        S_RD: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!e[0] || rsv) begin
            fault <= e[0] ? F_RSV : F_NP;
            {rt_user, rt_write, rt_exec} <= 3'b000;
            st <= S_DONE;
          end else begin
            ent <= newe;
            leaf_q <= leaf;
            rt_user <= rt_user & e[2];
            rt_write <= rt_write & e[1];
            rt_exec <= rt_exec & ~e[63];
            if (leaf) begin
              pa <= (e[PHYS_BITS-1:0] & ~mask) | (va[PHYS_BITS-1:0] & mask);
              psize <= (lvl == 2'd2) ? 2'd2 : (lvl == 2'd1) ? 2'd1 : 2'd0;
            end
            if (newe != e) st <= S_WB;
            else if (leaf) st <= S_DONE;
            else begin
              tbl <= {12'h0, e[51:12], 12'h0};
              lvl <= lvl - 2'd1;
              st <= S_RD;
            end
          end
        end
        S_WB: if (mem_req_ready) begin
          if (leaf_q) st <= S_DONE;
          else begin
            tbl <= {12'h0, ent[51:12], 12'h0};
            lvl <= lvl - 2'd1;
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [63:0] mem_req_addr,
  input logic [63:0] mem_req_wdata,
  input logic [1:0]  fault,
  input logic [1:0]  psize
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));
  p_mem_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_entry_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);
  p_wb_accessed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[5] && mem_req_wdata[0]);
  p_size_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 2'd0 |-> psize != 2'd3);
  p_fault_nosize_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault != 2'd0 |-> psize == 2'd0);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .fault(fault), .psize(psize)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  localparam int PB = 40;
  localparam logic [63:0] P = 64'h1, W = 64'h2, U = 64'h4, A = 64'h20, D = 64'h40, PS = 64'h80;
  localparam logic [63:0] NX = 64'h8000_0000_0000_0000;
  localparam logic [63:0] T4 = 64'h100000, T3 = 64'h101000, T2 = 64'h102000, T1 = 64'h103000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, nxe = 1'b1;
  logic [63:0] req_vaddr = '0, root = 64'h0010_0ABC;
  logic busy, mem_req_valid, mem_req_we, done, rt_user, rt_write, rt_exec;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [63:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata = '0;
  logic [1:0] fault, psize;
  logic [PB-1:0] pa;

  always #10 clk = ~clk;

  pt_walker #(.PHYS_BITS(PB)) u0 (.*);

  logic [63:0] mem [logic [63:0]];
  int rcnt = 0, wcnt = 0, tick = 0;
  always @(posedge clk) begin
    tick <= tick + 1;
    mem_req_ready <= (tick % 4) != 3;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr] = mem_req_wdata;
        wcnt <= wcnt + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
        rcnt <= rcnt + 1;
      end
    end
  end

  typedef struct packed {
    logic [1:0] kind; logic [PB-1:0] pa; logic [1:0] sz;
    logic u, w, x; int reads, writes, r0, w0;
  } exp_t;
  exp_t q[$];
  string tq[$];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [63:0] mkva(int i4, int i3, int i2, int i1, int off);
    logic [63:0] v;
    v = (64'(i4) << 39) | (64'(i3) << 30) | (64'(i2) << 21) | (64'(i1) << 12) | 64'(off);
    if (v[47]) v[63:48] = 16'hFFFF;
    return v;
  endfunction

  function automatic exp_t ok_e(logic [PB-1:0] a, logic [1:0] s, logic u, logic w, logic x,
                                int r, int wr);
    exp_t e;
    e = '0; e.kind = 2'd0; e.pa = a; e.sz = s; e.u = u; e.w = w; e.x = x;
    e.reads = r; e.writes = wr;
    return e;
  endfunction

  function automatic exp_t flt_e(logic [1:0] k, int r, int wr);
    exp_t e;
    e = '0; e.kind = k; e.reads = r; e.writes = wr;
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(1'b0, "R11", "unexpected done", 64'h1, 64'h0);
      else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        chk(fault == e.kind, t, "fault code", 64'(fault), 64'(e.kind));
        chk(psize == e.sz, t, "page size", 64'(psize), 64'(e.sz));
        chk({rt_user, rt_write, rt_exec} == {e.u, e.w, e.x}, t, "rights uwx",
            64'({rt_user, rt_write, rt_exec}), 64'({e.u, e.w, e.x}));
        if (e.kind == 2'd0) chk(pa == e.pa, t, "physical address", 64'(pa), 64'(e.pa));
        chk(rcnt - e.r0 == e.reads, {t, " R12"}, "entry reads", 64'(rcnt - e.r0), 64'(e.reads));
        chk(wcnt - e.w0 == e.writes, t, "write-backs", 64'(wcnt - e.w0), 64'(e.writes));
      end
    end
  end

  task automatic walk(input logic [63:0] v, input logic wrt, input exp_t e, input string tag,
                      input bit stray);
    @(negedge clk);
    e.r0 = rcnt; e.w0 = wcnt;
    q.push_back(e); tq.push_back(tag);
    req_vaddr = v; req_write = wrt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R11", "busy after request", 64'(busy), 64'h1);
    if (stray) begin
      @(negedge clk);
      req_vaddr = 64'h0000_8000_0000_0000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic ent_chk(input logic [63:0] addr, input logic [63:0] expv, input string tag);
    logic [63:0] a;
    a = mem.exists(addr) ? mem[addr] : 64'h0;
    chk(a == expv, tag, "entry in memory", a, expv);
  endtask

  bit finished = 1'b0;
  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    mem[T4 + 8*1]   = T3 | P | W | U;
    mem[T3 + 8*2]   = T2 | P | W | U | A;
    mem[T2 + 8*3]   = T1 | P | W | U | A;
    mem[T1 + 8*4]   = 64'h0ABCD000 | P | W | U;
    mem[T2 + 8*5]   = 64'h00400000 | P | W | A | D | PS | NX;
    mem[T2 + 8*6]   = 64'h00601000 | P | U | A | PS;
    mem[T2 + 8*7]   = 64'h00602000 | P | W | U | A | PS;
    mem[T3 + 8*3]   = 64'h40000000 | P | W | U | A | D | PS;
    mem[T3 + 8*4]   = 64'h40200000 | P | W | U | A | PS;
    mem[T3 + 8*6]   = (64'h1 << 45) | T2 | P | W | U | A;
    mem[T3 + 8*7]   = T2 | P | U | A | NX;
    mem[T4 + 8*2]   = T3 | P | W | U | A | PS;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && mem_req_valid == 1'b0, "R11", "reset state",
        64'({busy, done, mem_req_valid}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R11", "idle busy", 64'(busy), 64'h0);

    // R2 R10 R5 R9: 4K read with clear accessed bits, stray request while busy
    walk(mkva(1, 2, 3, 4, 12'h567), 1'b0, ok_e(40'h0ABCD567, 2'd0, 1, 1, 1, 4, 2), "R10", 1'b1);
    ent_chk(T4 + 8*1, T3 | P | W | U | A, "R5");
    ent_chk(T1 + 8*4, 64'h0ABCD000 | P | W | U | A, "R9");
    // R9: write sets dirty only
    walk(mkva(1, 2, 3, 4, 12'h567), 1'b1, ok_e(40'h0ABCD567, 2'd0, 1, 1, 1, 4, 1), "R9", 1'b0);
    ent_chk(T1 + 8*4, 64'h0ABCD000 | P | W | U | A | D, "R9");
    // R9: nothing to change
    walk(mkva(1, 2, 3, 4, 12'h567), 1'b0, ok_e(40'h0ABCD567, 2'd0, 1, 1, 1, 4, 0), "R9", 1'b0);
    // R6 R8: 2M page, user cleared, NX set
    walk(mkva(1, 2, 5, 8'h1A, 12'h123), 1'b0, ok_e(40'h0041A123, 2'd1, 0, 1, 0, 3, 0), "R6", 1'b0);
    // R7: bit 12 exempt, not in address
    walk(mkva(1, 2, 6, 8'h1A, 12'h123), 1'b0, ok_e(40'h0061A123, 2'd1, 1, 0, 1, 3, 0), "R7", 1'b0);
    // R7: misaligned 2M
    walk(mkva(1, 2, 7, 0, 0), 1'b0, flt_e(2'd3, 3, 0), "R7", 1'b0);
    // R6: 1G page
    walk(mkva(1, 3, 8'h11, 8'h22, 12'h333), 1'b0, ok_e(40'h42222333, 2'd2, 1, 1, 1, 2, 0), "R6", 1'b0);
    // R7: misaligned 1G
    walk(mkva(1, 4, 0, 0, 0), 1'b0, flt_e(2'd3, 2, 0), "R7", 1'b0);
    // R3: absent entry
    walk(mkva(1, 5, 0, 0, 0), 1'b1, flt_e(2'd2, 2, 0), "R3", 1'b0);
    // R4: bit above physical width
    walk(mkva(1, 6, 3, 4, 0), 1'b0, flt_e(2'd3, 2, 0), "R4", 1'b0);
    // R4: page-size bit in top entry
    walk(mkva(2, 0, 0, 0, 0), 1'b0, flt_e(2'd3, 1, 0), "R4", 1'b0);
    // R8: write dropped and NX on middle entry, fetch access
    walk(mkva(1, 7, 3, 4, 12'h567), 1'b0, ok_e(40'h0ABCD567, 2'd0, 1, 0, 0, 4, 0), "R8", 1'b0);
    // R1: non-canonical, and upper-half canonical
    walk(64'h0000_8000_0000_0000, 1'b0, flt_e(2'd1, 0, 0), "R1", 1'b0);
    walk(64'h7FFF_0000_0000_0000, 1'b1, flt_e(2'd1, 0, 0), "R1", 1'b0);
    walk(64'hFFFF_8000_0000_0000, 1'b0, flt_e(2'd2, 1, 0), "R1", 1'b0);
    // R4: NX bit while no-execute disabled
    nxe = 1'b0;
    walk(mkva(1, 2, 5, 0, 0), 1'b0, flt_e(2'd3, 3, 0), "R4", 1'b0);
    nxe = 1'b1;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule